// File: doc/BRIEF.md
# Privileged Control Register Bank with Write Screening

This block holds the processor control registers at indices 0, 2, 3, 4 and 8 and serves the move-to and move-from control-register operations of the core. Each access presents an index, a read or write strobe, write data, the current privilege level and a flag that says whether the core runs in 64-bit mode. Every access is screened before it touches state. An access that breaks a rule raises a one-cycle fault pulse in the same cycle as the strobe and changes nothing.

The decoded mode flags from index 0 and the two page-level cache flags from index 3 come straight from the storage flops, so the rest of the core sees them without any decode. A task-switch pulse from the core sets the task-switched flag directly.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After reset, index 0 reads 0x10, indices 2, 3, 4 and 8 read 0, every flag output is low and both fault outputs are low.
- R2: Any read or write with `priv_lvl` not equal to 0 raises `gp_fault` and not `ud_fault`, and changes neither the registers nor `rd_data`. The privilege check comes first, ahead of every other check.
- R3: An access to index 1, 5, 6, 7 or 9 to 15, or to index 8 while `mode64` is low, raises `ud_fault` and leaves state unchanged. This check comes after the privilege check and before the data checks.
- R4: A write to index 0 or 4 with any of bits 63:32 set raises `gp_fault`, and the register keeps its old value.
- R5: A write to index 3 with any of bits 51:40 set raises `gp_fault`. A legal write stores bits 63:12 together with bit 4 (drives `pg_cache_dis`) and bit 3 (drives `pg_write_thru`). All other bits of 11:0 read as 0.
- R6: Index 2 stores all 64 written bits without any range check.
- R7: A write to index 0 with bit 31 set and bit 0 clear raises `gp_fault`, and index 0 keeps its old value.
- R8: Index 0 bit 4 always reads 1 and ignores writes. Only bits 31 (`paging_en`), 30 (`cache_dis`), 29 (`no_wr_thru`), 18 (`align_mask`), 16 (`wr_protect`), 5 (`num_err`), 3 (`task_sw`) and 0 (`prot_en`) are writable, and they drive the flag outputs. Every other bit reads 0.
- R9: A `task_switch` pulse sets bit 3 of index 0 in the next cycle. If a legal write to index 0 happens in the same cycle, the set wins over the written bit 3.
- R10: Index 8 stores the low TPR_W bits (4 by default). Higher written bits are dropped and read as 0.
- R11: When `acc_wr` is high the access is a write, otherwise `acc_rd` makes it a read. A legal read loads `rd_data` on the next clock edge. A read that faults leaves `rd_data` unchanged.
- R12: At most one fault output is high in any cycle. A fault is high only in a cycle where a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_idx | input | 4 | Control register index |
| acc_wdata | input | 64 | Write data |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| priv_lvl | input | 2 | Current privilege level |
| mode64 | input | 1 | 64-bit mode active |
| task_switch | input | 1 | Task-switch pulse, sets the task-switched flag |
| rd_data | output | 64 | Read data, valid the cycle after a legal read |
| gp_fault | output | 1 | General-protection fault pulse |
| ud_fault | output | 1 | Undefined-register fault pulse |
| paging_en | output | 1 | Paging enable |
| prot_en | output | 1 | Protection enable |
| cache_dis | output | 1 | Cache disable |
| no_wr_thru | output | 1 | Not write-through |
| align_mask | output | 1 | Alignment mask |
| wr_protect | output | 1 | Supervisor write protect |
| num_err | output | 1 | Native numeric error reporting |
| task_sw | output | 1 | Task switched |
| pg_cache_dis | output | 1 | Page-level cache disable |
| pg_write_thru | output | 1 | Page-level write-through |

## Verification
The bench builds the block with its default parameters: a 64-bit register width, a 32-bit legal field for indices 0 and 4, a 4-bit priority field and the reserved window at 51:40. With these defaults every fault rule sits at a real bit boundary. Bit 32 falls just past the legal field, bit 40 is the lowest reserved base-address bit, and data above bit 3 written to index 8 shows that the priority field is cut off. The same defaults also let the bench test the order of the checks on accesses that break two rules at once.

// File: rtl/cr_pkg.sv
package cr_pkg;

  localparam int unsigned PG_POS = 31;
  localparam int unsigned CD_POS = 30;
  localparam int unsigned NW_POS = 29;
  localparam int unsigned AM_POS = 18;
  localparam int unsigned WP_POS = 16;
  localparam int unsigned NE_POS = 5;
  localparam int unsigned ET_POS = 4;
  localparam int unsigned TS_POS = 3;
  localparam int unsigned PE_POS = 0;

  localparam int unsigned PCD_POS = 4;
  localparam int unsigned PWT_POS = 3;

  localparam logic [31:0] CR0_WR_MASK =
      (32'h1 << PG_POS) | (32'h1 << CD_POS) | (32'h1 << NW_POS) |
      (32'h1 << AM_POS) | (32'h1 << WP_POS) | (32'h1 << NE_POS) |
      (32'h1 << TS_POS) | (32'h1 << PE_POS);

  localparam logic [31:0] CR0_FIXED_ONE = 32'h1 << ET_POS;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2
  } fault_e;

  typedef struct packed {
    logic pg;
    logic cd;
    logic nw;
    logic am;
    logic wp;
    logic ne;
    logic ts;
    logic pe;
  } mode_flags_t;

endpackage

// File: rtl/cr_access_check.sv
module cr_access_check
  import cr_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned LOW_W      = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned CR3_RSV_LO = 40,
  parameter int unsigned CR3_RSV_HI = 51
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  wdata,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       cpl,
  input  logic             long_mode,
  output fault_e           fault,
  output logic             legal_wr,
  output logic             legal_rd
);

  localparam logic [IDX_W-1:0] IDX0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX2 = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX3 = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX4 = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX8 = IDX_W'(8);

  logic access;
  logic present;
  logic upper_bad;
  logic cr3_rsv_bad;
  logic rsv_bad;
  logic combo_bad;

  always_comb begin
    access      = wr | rd;
    present     = (idx == IDX0) || (idx == IDX2) || (idx == IDX3) ||
                  (idx == IDX4) || ((idx == IDX8) && long_mode);
    upper_bad   = |wdata[XLEN-1:LOW_W];
    cr3_rsv_bad = |wdata[CR3_RSV_HI:CR3_RSV_LO];
    rsv_bad     = 1'b0;
    if ((idx == IDX0) || (idx == IDX4)) rsv_bad = upper_bad;
    else if (idx == IDX3)               rsv_bad = cr3_rsv_bad;
    combo_bad   = (idx == IDX0) && wdata[PG_POS] && !wdata[PE_POS];
  end

  // Check order: privilege, existence, reserved bits, flag combination
  always_comb begin
    fault = FLT_NONE;
    if (access) begin
      if (cpl != 2'd0)                  fault = FLT_GP;
      else if (!present)                fault = FLT_UD;
      else if (wr && rsv_bad)           fault = FLT_GP;
      else if (wr && combo_bad)         fault = FLT_GP;
    end
    legal_wr = wr && (fault == FLT_NONE);
    legal_rd = !wr && rd && (fault == FLT_NONE);
  end

endmodule

// File: rtl/cr_storage.sv
module cr_storage
  import cr_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned LOW_W      = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned TPR_W      = 4,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legal_wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  wdata,
  input  logic             task_switch,
  output logic [XLEN-1:0]  cr0_view,
  output logic [XLEN-1:0]  cr2_view,
  output logic [XLEN-1:0]  cr3_view,
  output logic [XLEN-1:0]  cr4_view,
  output logic [XLEN-1:0]  cr8_view,
  output mode_flags_t      flags,
  output logic             pcd,
  output logic             pwt
);

  localparam logic [IDX_W-1:0] IDX0 = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX2 = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX3 = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX4 = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX8 = IDX_W'(8);
  localparam int unsigned BASE_W = XLEN - PAGE_SHIFT;

  logic [BASE_W-1:0] cr3_base;
  logic [LOW_W-1:0]  cr4_q;
  logic [TPR_W-1:0]  cr8_q;
  logic [XLEN-1:0]   cr2_q;

  logic wr0, wr2, wr3, wr4, wr8;
  always_comb begin
    wr0 = legal_wr && (idx == IDX0);
    wr2 = legal_wr && (idx == IDX2);
    wr3 = legal_wr && (idx == IDX3);
    wr4 = legal_wr && (idx == IDX4);
    wr8 = legal_wr && (idx == IDX8);
  end

  // Index 0 mode flags; task switch pulse dominates a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      if (wr0) begin
        flags.pg <= wdata[PG_POS];
        flags.cd <= wdata[CD_POS];
        flags.nw <= wdata[NW_POS];
        flags.am <= wdata[AM_POS];
        flags.wp <= wdata[WP_POS];
        flags.ne <= wdata[NE_POS];
        flags.pe <= wdata[PE_POS];
        flags.ts <= wdata[TS_POS];
      end
      if (task_switch) flags.ts <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr2_q    <= '0;
      cr3_base <= '0;
      pcd      <= 1'b0;
      pwt      <= 1'b0;
      cr4_q    <= '0;
      cr8_q    <= '0;
    end else begin
      if (wr2) cr2_q <= wdata;
      if (wr3) begin
        cr3_base <= wdata[XLEN-1:PAGE_SHIFT];
        pcd      <= wdata[PCD_POS];
        pwt      <= wdata[PWT_POS];
      end
      if (wr4) cr4_q <= wdata[LOW_W-1:0];
      if (wr8) cr8_q <= wdata[TPR_W-1:0];
    end
  end

  always_comb begin
    cr0_view          = XLEN'(CR0_FIXED_ONE);
    cr0_view[PG_POS]  = flags.pg;
    cr0_view[CD_POS]  = flags.cd;
    cr0_view[NW_POS]  = flags.nw;
    cr0_view[AM_POS]  = flags.am;
    cr0_view[WP_POS]  = flags.wp;
    cr0_view[NE_POS]  = flags.ne;
    cr0_view[TS_POS]  = flags.ts;
    cr0_view[PE_POS]  = flags.pe;

    cr2_view = cr2_q;

    cr3_view                       = '0;
    cr3_view[XLEN-1:PAGE_SHIFT]    = cr3_base;
    cr3_view[PCD_POS]              = pcd;
    cr3_view[PWT_POS]              = pwt;

    cr4_view = XLEN'(cr4_q);
    cr8_view = XLEN'(cr8_q);
  end

endmodule

// File: rtl/cr_read_port.sv
module cr_read_port #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             legal_rd,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  cr0_view,
  input  logic [XLEN-1:0]  cr2_view,
  input  logic [XLEN-1:0]  cr3_view,
  input  logic [XLEN-1:0]  cr4_view,
  input  logic [XLEN-1:0]  cr8_view,
  output logic [XLEN-1:0]  rd_data
);

  logic [XLEN-1:0] sel;

  always_comb begin
    unique case (idx)
      IDX_W'(0): sel = cr0_view;
      IDX_W'(2): sel = cr2_view;
      IDX_W'(3): sel = cr3_view;
      IDX_W'(4): sel = cr4_view;
      IDX_W'(8): sel = cr8_view;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (legal_rd) rd_data <= sel;
  end

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import cr_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned LOW_W      = 32,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned TPR_W      = 4,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned CR3_RSV_LO = 40,
  parameter int unsigned CR3_RSV_HI = 51
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [XLEN-1:0]  acc_wdata,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic [1:0]       priv_lvl,
  input  logic             mode64,
  input  logic             task_switch,
  output logic [XLEN-1:0]  rd_data,
  output logic             gp_fault,
  output logic             ud_fault,
  output logic             paging_en,
  output logic             prot_en,
  output logic             cache_dis,
  output logic             no_wr_thru,
  output logic             align_mask,
  output logic             wr_protect,
  output logic             num_err,
  output logic             task_sw,
  output logic             pg_cache_dis,
  output logic             pg_write_thru
);

  fault_e          fault;
  logic            legal_wr;
  logic            legal_rd;
  logic [XLEN-1:0] cr0_view, cr2_view, cr3_view, cr4_view, cr8_view;
  mode_flags_t     flags;

  cr_access_check #(
    .XLEN(XLEN), .LOW_W(LOW_W), .IDX_W(IDX_W),
    .CR3_RSV_LO(CR3_RSV_LO), .CR3_RSV_HI(CR3_RSV_HI)
  ) u_check (
    .idx(acc_idx), .wdata(acc_wdata), .wr(acc_wr), .rd(acc_rd),
    .cpl(priv_lvl), .long_mode(mode64),
    .fault(fault), .legal_wr(legal_wr), .legal_rd(legal_rd)
  );

  cr_storage #(
    .XLEN(XLEN), .LOW_W(LOW_W), .IDX_W(IDX_W),
    .TPR_W(TPR_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_store (
    .clk(clk), .rst(rst), .legal_wr(legal_wr), .idx(acc_idx),
    .wdata(acc_wdata), .task_switch(task_switch),
    .cr0_view(cr0_view), .cr2_view(cr2_view), .cr3_view(cr3_view),
    .cr4_view(cr4_view), .cr8_view(cr8_view),
    .flags(flags), .pcd(pg_cache_dis), .pwt(pg_write_thru)
  );

  cr_read_port #(
    .XLEN(XLEN), .IDX_W(IDX_W)
  ) u_read (
    .clk(clk), .rst(rst), .legal_rd(legal_rd), .idx(acc_idx),
    .cr0_view(cr0_view), .cr2_view(cr2_view), .cr3_view(cr3_view),
    .cr4_view(cr4_view), .cr8_view(cr8_view), .rd_data(rd_data)
  );

  always_comb begin
    gp_fault   = (fault == FLT_GP);
    ud_fault   = (fault == FLT_UD);
    paging_en  = flags.pg;
    prot_en    = flags.pe;
    cache_dis  = flags.cd;
    no_wr_thru = flags.nw;
    align_mask = flags.am;
    wr_protect = flags.wp;
    num_err    = flags.ne;
    task_sw    = flags.ts;
  end

endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] acc_idx,
  input logic [XLEN-1:0]  acc_wdata,
  input logic             acc_wr,
  input logic             acc_rd,
  input logic [1:0]       priv_lvl,
  input logic             mode64,
  input logic             task_switch,
  input logic [XLEN-1:0]  rd_data,
  input logic             gp_fault,
  input logic             ud_fault,
  input logic             paging_en,
  input logic             prot_en,
  input logic             cache_dis,
  input logic             no_wr_thru,
  input logic             align_mask,
  input logic             wr_protect,
  input logic             num_err,
  input logic             task_sw,
  input logic             pg_cache_dis,
  input logic             pg_write_thru
);

  a_r2_priv_gp: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && priv_lvl != 2'd0) |-> (gp_fault && !ud_fault));

  a_r3_cr8_needs_mode: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && priv_lvl == 2'd0 && acc_idx == IDX_W'(8) && !mode64)
      |-> ud_fault);

  a_r4_upper_gp: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && priv_lvl == 2'd0 && (acc_idx == IDX_W'(0) || acc_idx == IDX_W'(4))
      && |acc_wdata[XLEN-1:32]) |-> gp_fault);

  a_r4_fault_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    ((gp_fault || ud_fault) && !task_switch) |=>
      $stable({paging_en, prot_en, cache_dis, no_wr_thru, align_mask,
               wr_protect, num_err, task_sw, pg_cache_dis, pg_write_thru}));

  a_r7_pg_needs_pe: assert property (@(posedge clk) disable iff (rst)
    paging_en |-> prot_en);

  a_r9_ts_set: assert property (@(posedge clk) disable iff (rst)
    task_switch |=> task_sw);

  a_r11_fault_holds_rd: assert property (@(posedge clk) disable iff (rst)
    (gp_fault || ud_fault) |=> $stable(rd_data));

  a_r12_one_fault: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gp_fault, ud_fault}));

  a_r12_fault_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (gp_fault || ud_fault) |-> (acc_wr || acc_rd));

endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_ctrl_reg_bank.sv
module test_ctrl_reg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  acc_idx = '0;
  logic [63:0] acc_wdata = '0;
  logic        acc_wr = 1'b0;
  logic        acc_rd = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic        mode64 = 1'b0;
  logic        task_switch = 1'b0;
  logic [63:0] rd_data;
  logic        gp_fault, ud_fault;
  logic        paging_en, prot_en, cache_dis, no_wr_thru, align_mask;
  logic        wr_protect, num_err, task_sw, pg_cache_dis, pg_write_thru;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  ctrl_reg_bank i_ctrl_reg_bank (.*);

  typedef struct packed {
    logic        wr;
    logic [3:0]  idx;
    logic [1:0]  cpl;
    logic        lm;
    logic [63:0] d;
    logic        gp;
    logic        ud;
    logic [63:0] rd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'h10},                 // R1
    '{1'b0, 4'd3, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'h0},                  // R1
    '{1'b1, 4'd0, 2'd0, 1'b0, 64'h8000_0000,           1'b1, 1'b0, 64'h0},                  // R7
    '{1'b0, 4'd0, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'h10},                 // R7
    '{1'b1, 4'd0, 2'd0, 1'b0, 64'hFFFF_FFFF,           1'b0, 1'b0, 64'h0},                  // R8
    '{1'b0, 4'd0, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'hE005_0039},          // R8
    '{1'b1, 4'd0, 2'd0, 1'b0, 64'h1_0000_0000,         1'b1, 1'b0, 64'h0},                  // R4
    '{1'b0, 4'd0, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'hE005_0039},          // R4
    '{1'b1, 4'd0, 2'd3, 1'b0, 64'h0,                   1'b1, 1'b0, 64'h0},                  // R2
    '{1'b0, 4'd0, 2'd1, 1'b0, 64'h0,                   1'b1, 1'b0, 64'h0},                  // R2
    '{1'b1, 4'd2, 2'd0, 1'b0, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0, 64'h0},                  // R6
    '{1'b0, 4'd2, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'hDEAD_BEEF_1234_5678},// R6
    '{1'b1, 4'd3, 2'd0, 1'b0, 64'h0000_0100_0000_0000, 1'b1, 1'b0, 64'h0},                  // R5
    '{1'b1, 4'd3, 2'd0, 1'b0, 64'hFFF0_00FF_FFFF_FFFF, 1'b0, 1'b0, 64'h0},                  // R5
    '{1'b0, 4'd3, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'hFFF0_00FF_FFFF_F018},// R5
    '{1'b1, 4'd1, 2'd0, 1'b1, 64'h0,                   1'b0, 1'b1, 64'h0},                  // R3
    '{1'b0, 4'd5, 2'd0, 1'b1, 64'h0,                   1'b0, 1'b1, 64'h0},                  // R3
    '{1'b1, 4'd8, 2'd0, 1'b0, 64'h3,                   1'b0, 1'b1, 64'h0},                  // R3
    '{1'b1, 4'd8, 2'd0, 1'b1, 64'hFF,                  1'b0, 1'b0, 64'h0},                  // R10
    '{1'b0, 4'd8, 2'd0, 1'b1, 64'h0,                   1'b0, 1'b0, 64'hF},                  // R10
    '{1'b1, 4'd4, 2'd0, 1'b0, 64'h1_0000_0000,         1'b1, 1'b0, 64'h0},                  // R4
    '{1'b1, 4'd4, 2'd0, 1'b0, 64'h0012_3456,           1'b0, 1'b0, 64'h0},                  // R4
    '{1'b0, 4'd4, 2'd0, 1'b0, 64'h0,                   1'b0, 1'b0, 64'h0012_3456},          // R4
    '{1'b1, 4'd1, 2'd2, 1'b1, 64'h0,                   1'b1, 1'b0, 64'h0},                  // R2 before R3
    '{1'b1, 4'd0, 2'd0, 1'b0, 64'h1_8000_0000,         1'b1, 1'b0, 64'h0}                   // R4, R12 single fault
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] idx, input logic [1:0] cpl,
                        input logic lm, input logic [63:0] d, input logic ts);
    @(negedge clk);
    acc_wr = wr; acc_rd = !wr; acc_idx = idx; priv_lvl = cpl;
    mode64 = lm; acc_wdata = d; task_switch = ts;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0; task_switch = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rd_data", rd_data, 64'h0);
    chk("R1 flags", {54'h0, paging_en, prot_en, cache_dis, no_wr_thru, align_mask,
                     wr_protect, num_err, task_sw, pg_cache_dis, pg_write_thru}, 64'h0);
    chk("R1 faults", {62'h0, gp_fault, ud_fault}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] prev;
      prev = rd_data;
      @(negedge clk);
      acc_wr = VEC[i].wr; acc_rd = !VEC[i].wr; acc_idx = VEC[i].idx;
      priv_lvl = VEC[i].cpl; mode64 = VEC[i].lm; acc_wdata = VEC[i].d;
      #1;
      chk($sformatf("R12 vec%0d gp", i), {63'h0, gp_fault}, {63'h0, VEC[i].gp});
      chk($sformatf("R12 vec%0d ud", i), {63'h0, ud_fault}, {63'h0, VEC[i].ud});
      @(negedge clk);
      acc_wr = 1'b0; acc_rd = 1'b0;
      #1;
      if (VEC[i].gp || VEC[i].ud)
        chk($sformatf("R12 vec%0d pulse ends", i), {62'h0, gp_fault, ud_fault}, 64'h0);
      if (!VEC[i].wr) begin
        if (VEC[i].gp || VEC[i].ud)
          chk($sformatf("R11 vec%0d faulted read", i), rd_data, prev);
        else
          chk($sformatf("R11 vec%0d read", i), rd_data, VEC[i].rd);
      end
      if (i == 5)
        chk("R8 flag outputs", {56'h0, paging_en, cache_dis, no_wr_thru, align_mask,
                                wr_protect, num_err, task_sw, prot_en}, 64'hFF);
      if (i == 14)
        chk("R5 page cache flags", {62'h0, pg_cache_dis, pg_write_thru}, 64'h3);
    end

    // R9: write clears TS, pulse sets it, pulse beats a same-cycle write
    access(1'b1, 4'd0, 2'd0, 1'b0, 64'h8000_0001, 1'b0);
    #1 chk("R9 ts cleared by write", {63'h0, task_sw}, 64'h0);
    @(negedge clk); task_switch = 1'b1;
    @(negedge clk); task_switch = 1'b0;
    #1 chk("R9 ts set by pulse", {63'h0, task_sw}, 64'h1);
    access(1'b1, 4'd0, 2'd0, 1'b0, 64'h8000_0001, 1'b1);
    #1 chk("R9 pulse wins over write", {63'h0, task_sw}, 64'h1);
    access(1'b0, 4'd0, 2'd0, 1'b0, 64'h0, 1'b0);
    #1 chk("R9 R8 readback", rd_data, 64'h8000_0019);

    // R1: reset in the middle of operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 chk("R1 flags after reset", {62'h0, paging_en, task_sw}, 64'h0);
    access(1'b0, 4'd0, 2'd0, 1'b0, 64'h0, 1'b0);
    #1 chk("R1 index0 after reset", rd_data, 64'h10);
    access(1'b0, 4'd2, 2'd0, 1'b0, 64'h0, 1'b0);
    #1 chk("R1 index2 after reset", rd_data, 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule